// File: doc/BRIEF.md
# Frame receive queue with host read window

This block holds accepted receive frames in a byte-wide circular store and gives a host random access to the oldest complete frame through a small read window. A receive engine writes a frame one byte at a time. It then either commits the frame as a unit or abandons it. Bytes of a frame that is still being written are never visible to the host, and a frame that is abandoned or rejected leaves nothing behind.

The first byte of every frame is its total length in bytes, counting the length byte itself. The host selects a byte offset and reads that byte of the oldest frame combinationally. When the host issues a release, the queue moves past that frame to the next one. The receive side keeps filling the free space behind the frame the host is reading. A frame that would overwrite data not yet released is dropped and flagged as an overrun. Status outputs report whether a frame is waiting, how many frames are held, and the sticky overrun flag.

Top module: `rxq_window_fifo`

## Requirements
- R1: After reset, `rx_avail` is 0, `frame_count` is 0 and `overrun` is 0.
- R2: The store holds 64 bytes and is used circularly. Window offset k (k < 13) returns byte k of the oldest committed frame, and addresses wrap modulo 64, including for frames that straddle the end of the store.
- R3: A committed frame is kept only if its byte count equals the value of its first byte and lies between 1 and 13. A commit with no bytes, with a count that differs from the first byte, or with more than 13 bytes drops the frame silently. A silent drop does not set `overrun`, and the next stored frame starts where the dropped one began.
- R4: `wr_abort` discards the pending bytes. `frame_count`, the window and the next frame's position are unchanged, exactly as if the aborted bytes had never been sent.
- R5: `frame_count` equals committed frames minus released frames, and `rx_avail` is 1 exactly when `frame_count` is non-zero.
- R6: A `frame_release` pulse while a frame is held moves the window to the next frame, advancing by the first byte's value, and decrements `frame_count`. A release while no frame is held is ignored.
- R7: A frame with more bytes than the free space (64 minus the bytes of unreleased frames) is dropped on commit and sets `overrun`. Frames committed earlier stay readable and unchanged. `overrun` stays set until a cycle with `ovr_clr` high and no new overrun.
- R8: Window offsets 13, 14 and 15 read 0.
- R9: Frames may be written and committed while the host reads and releases. The pending frame does not change `frame_count`. A commit and a release in the same cycle leave `frame_count` unchanged.
- R10: A `wr_valid` byte presented in the same cycle as `wr_commit` or `wr_abort` is ignored and does not become part of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Receive side presents one frame byte |
| wr_data | input | 8 | Frame byte; the first byte of a frame is its length |
| wr_commit | input | 1 | End of frame: keep it if well formed and fitting |
| wr_abort | input | 1 | Discard the pending frame |
| win_offset | input | 4 | Byte offset into the oldest frame |
| win_data | output | 8 | Byte at `win_offset` of the oldest frame (combinational) |
| frame_release | input | 1 | Host is done with the oldest frame |
| ovr_clr | input | 1 | Clear the overrun flag |
| rx_avail | output | 1 | At least one frame is held |
| frame_count | output | 7 | Number of frames held |
| overrun | output | 1 | Sticky: a frame was dropped for lack of space |

## Verification
A read pointer that drifts by even one byte shows at once as every window byte of the next frame being wrong. It also shows as a wrong advance on the following release, so the first window read after a bad release exposes it. A write tail that is off, or a bad free-space computation, appears in two ways: the first byte of the next stored frame differs from its length, or committed frames that should survive an overrun come back corrupted. The bench therefore reads every byte of every frame it releases. A frame counter out of step with the stored bytes is visible at the next commit or release through `frame_count` and `rx_avail`.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef logic [7:0] rxq_byte_t;

    // Outcome of an end-of-frame request on the receive side
    typedef enum logic [1:0] {
        CMT_NONE      = 2'd0,
        CMT_KEEP      = 2'd1,
        CMT_MALFORMED = 2'd2,
        CMT_NOFIT     = 2'd3
    } rxq_cmt_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  rxq_byte_t     wdata,
    input  logic [AW-1:0] raddr_a,
    output rxq_byte_t     rdata_a,
    input  logic [AW-1:0] raddr_b,
    output rxq_byte_t     rdata_b
);
    localparam int DEPTH = 1 << AW;

    rxq_byte_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/rxq_wr_ctrl.sv
module rxq_wr_ctrl
    import rxq_pkg::*;
#(
    parameter int AW  = 6,
    parameter int WIN = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  rxq_byte_t     wr_data,
    input  logic          wr_commit,
    input  logic          wr_abort,
    input  logic          ovr_clr,
    input  logic [AW:0]   rd_ptr,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output rxq_byte_t     mem_wdata,
    output logic [AW:0]   tail_ptr,
    output logic          cmt_ok,
    output logic          overrun
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);
    localparam logic [PW-1:0] WIN_P   = PW'(WIN);

    typedef struct packed {
        logic [PW-1:0] tail;
        logic [PW-1:0] pcnt;
        rxq_byte_t     plen;
        logic          nofit;
        logic          toolong;
        logic          ovr;
    } wr_state_t;

    wr_state_t s_q, s_d;
    logic [PW-1:0] used_w, free_w;
    rxq_cmt_e      res_w;

    always_comb begin
        s_d       = s_q;
        mem_we    = 1'b0;
        mem_waddr = s_q.tail[AW-1:0] + s_q.pcnt[AW-1:0];
        mem_wdata = wr_data;
        used_w    = s_q.tail - rd_ptr;
        free_w    = DEPTH_P - used_w;
        res_w     = CMT_NONE;

        if (wr_commit) begin
            if (s_q.nofit) begin
                res_w = CMT_NOFIT;
            end else if (s_q.toolong || (s_q.pcnt == '0) ||
                         ({8'd0, s_q.pcnt} != {{PW{1'b0}}, s_q.plen})) begin
                res_w = CMT_MALFORMED;
            end else begin
                res_w = CMT_KEEP;
            end
        end

        if (ovr_clr) begin
            s_d.ovr = 1'b0;
        end

        case (res_w)
            CMT_KEEP:  s_d.tail = s_q.tail + s_q.pcnt;
            CMT_NOFIT: s_d.ovr  = 1'b1;
            default:   ;
        endcase

        if (wr_commit || wr_abort) begin
            s_d.pcnt    = '0;
            s_d.plen    = '0;
            s_d.nofit   = 1'b0;
            s_d.toolong = 1'b0;
        end else if (wr_valid && !s_q.nofit && !s_q.toolong) begin
            if (s_q.pcnt >= WIN_P) begin
                s_d.toolong = 1'b1;
            end else if (s_q.pcnt >= free_w) begin
                s_d.nofit = 1'b1;
            end else begin
                mem_we = 1'b1;
                if (s_q.pcnt == '0) begin
                    s_d.plen = wr_data;
                end
                s_d.pcnt = s_q.pcnt + 1'b1;
            end
        end

        cmt_ok = (res_w == CMT_KEEP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tail_ptr = s_q.tail;
    assign overrun  = s_q.ovr;

    // R7: overrun is sticky until cleared
    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    // R7: a dropped frame never advances the tail
    p_nofit_keeps_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && s_q.nofit) |=> $stable(tail_ptr));

    // R4: abort never moves the committed tail
    p_abort_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_abort && !wr_commit) |=> $stable(tail_ptr));
endmodule

// File: rtl/rxq_rd_ctrl.sv
module rxq_rd_ctrl
    import rxq_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_release,
    input  logic        cmt_ok,
    input  rxq_byte_t   head_len,
    output logic [AW:0] rd_ptr,
    output logic [AW:0] frame_cnt
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] rptr;
        logic [PW-1:0] cnt;
    } rd_state_t;

    rd_state_t s_q, s_d;
    logic      rel_ok;

    always_comb begin
        s_d    = s_q;
        rel_ok = frame_release && (s_q.cnt != '0);
        if (rel_ok) begin
            s_d.rptr = s_q.rptr + PW'(head_len);
        end
        case ({cmt_ok, rel_ok})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_ptr    = s_q.rptr;
    assign frame_cnt = s_q.cnt;

    // R6: release with nothing held leaves the window where it is
    p_release_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_release && (frame_cnt == '0)) |=> $stable(rd_ptr));

    // R9: simultaneous commit and release keep the count
    p_cmt_rel_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_release && cmt_ok && (frame_cnt != '0)) |=> $stable(frame_cnt));
endmodule

// File: rtl/rxq_window_fifo.sv
module rxq_window_fifo
    import rxq_pkg::*;
#(
    parameter int AW  = 6,
    parameter int WIN = 13,
    parameter int OW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [7:0]    wr_data,
    input  logic          wr_commit,
    input  logic          wr_abort,
    input  logic [OW-1:0] win_offset,
    output logic [7:0]    win_data,
    input  logic          frame_release,
    input  logic          ovr_clr,
    output logic          rx_avail,
    output logic [AW:0]   frame_count,
    output logic          overrun
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    rxq_byte_t     mem_wdata;
    rxq_byte_t     head_len;
    rxq_byte_t     win_raw;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] tail_ptr;
    logic          cmt_ok;
    logic [AW-1:0] win_addr;
    logic [PW-1:0] used_w;

    assign win_addr = rd_ptr[AW-1:0] + AW'(win_offset);
    assign used_w   = tail_ptr - rd_ptr;

    rxq_store #(.AW(AW)) u_store (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (rd_ptr[AW-1:0]),
        .rdata_a (head_len),
        .raddr_b (win_addr),
        .rdata_b (win_raw)
    );

    rxq_wr_ctrl #(.AW(AW), .WIN(WIN)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .wr_commit (wr_commit),
        .wr_abort  (wr_abort),
        .ovr_clr   (ovr_clr),
        .rd_ptr    (rd_ptr),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .tail_ptr  (tail_ptr),
        .cmt_ok    (cmt_ok),
        .overrun   (overrun)
    );

    rxq_rd_ctrl #(.AW(AW)) u_rd (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_release (frame_release),
        .cmt_ok        (cmt_ok),
        .head_len      (head_len),
        .rd_ptr        (rd_ptr),
        .frame_cnt     (frame_count)
    );

    always_comb begin
        win_data = '0;
        if (int'(win_offset) < WIN) begin
            win_data = win_raw;
        end
    end

    assign rx_avail = (frame_count != '0);

    // R2: committed bytes never exceed the store
    p_used_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        used_w <= DEPTH_P);

    // R5: every held frame owns at least one byte
    p_cnt_le_used_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_count <= used_w);

    // R5: no frames held exactly when no committed bytes are held
    p_empty_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_count == '0) == (used_w == '0));
endmodule

// File: tb/rxq_window_fifo_tb.sv
module rxq_window_fifo_tb;
    localparam int CLK_P = 10;
    localparam int WIN   = 13;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_commit = 1'b0;
    logic       wr_abort = 1'b0;
    logic [3:0] win_offset = '0;
    logic [7:0] win_data;
    logic       frame_release = 1'b0;
    logic       ovr_clr = 1'b0;
    logic       rx_avail;
    logic [6:0] frame_count;
    logic       overrun;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    int mq[$];
    int lq[$];
    int pend[$];
    bit m_ovr = 1'b0;
    bit p_nofit = 1'b0;
    bit p_long = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rxq_window_fifo u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_valid      (wr_valid),
        .wr_data       (wr_data),
        .wr_commit     (wr_commit),
        .wr_abort      (wr_abort),
        .win_offset    (win_offset),
        .win_data      (win_data),
        .frame_release (frame_release),
        .ovr_clr       (ovr_clr),
        .rx_avail      (rx_avail),
        .frame_count   (frame_count),
        .overrun       (overrun)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic void model_commit();
        if (p_nofit) begin
            m_ovr = 1'b1;
        end else if (!p_long && pend.size() > 0 && pend[0] == pend.size()) begin
            foreach (pend[i]) mq.push_back(pend[i]);
            lq.push_back(pend.size());
        end
        pend.delete();
        p_nofit = 1'b0;
        p_long  = 1'b0;
    endfunction

    function automatic void model_release();
        if (lq.size() > 0) begin
            for (int i = 0; i < lq[0]; i++) void'(mq.pop_front());
            void'(lq.pop_front());
        end
    endfunction

    task automatic push(int b);
        wr_valid = 1'b1;
        wr_data  = b[7:0];
        tick();
        wr_valid = 1'b0;
        if (!p_nofit && !p_long) begin
            if (pend.size() >= WIN) p_long = 1'b1;
            else if (pend.size() >= DEPTH - mq.size()) p_nofit = 1'b1;
            else pend.push_back(b & 255);
        end
    endtask

    task automatic commit();
        wr_commit = 1'b1;
        tick();
        wr_commit = 1'b0;
        model_commit();
    endtask

    task automatic abort_f();
        wr_abort = 1'b1;
        tick();
        wr_abort = 1'b0;
        pend.delete();
        p_nofit = 1'b0;
        p_long  = 1'b0;
    endtask

    task automatic release_f();
        frame_release = 1'b1;
        tick();
        frame_release = 1'b0;
        model_release();
    endtask

    task automatic send(int len, int n, int base);
        push(len);
        for (int i = 1; i < n; i++) push((base + i) & 255);
        commit();
    endtask

    task automatic chk_status(string req);
        chk(req, "rx_avail", int'(rx_avail), (lq.size() != 0) ? 1 : 0);
        chk(req, "frame_count", int'(frame_count), lq.size());
        chk(req, "overrun", int'(overrun), int'(m_ovr));
    endtask

    task automatic chk_window(string req);
        if (lq.size() > 0) begin
            for (int off = 0; off < lq[0]; off++) begin
                win_offset = 4'(off);
                #1;
                chk(req, "win_data", int'(win_data), mq[off]);
            end
        end
    endtask

    task automatic drain(string req);
        while (lq.size() > 0) begin
            chk_window(req);
            release_f();
            chk_status(req);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        chk("R1", "rx_avail", int'(rx_avail), 0);
        chk("R1", "frame_count", int'(frame_count), 0);
        chk("R1", "overrun", int'(overrun), 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_basic();
        send(5, 5, 8'h40);
        chk_status("R5");
        chk_window("R2");
        send(3, 3, 8'h70);
        chk_status("R5");
        chk_window("R2");
    endtask

    task automatic t_malformed();
        send(4, 6, 8'h90);      // count differs from length byte
        chk_status("R3");
        commit();               // empty commit
        chk_status("R3");
        send(14, 14, 8'hA0);    // longer than the window
        chk_status("R3");
        send(2, 2, 8'hB0);
        chk_status("R3");
        drain("R3");            // last frame must start at its own length byte
    endtask

    task automatic t_abort();
        send(4, 4, 8'h10);
        push(9); push(8'h55); push(8'h66);
        abort_f();
        chk_status("R4");
        chk_window("R4");
        send(6, 6, 8'h20);
        chk_status("R4");
        release_f();
        chk_window("R4");
        release_f();
        chk_status("R4");
    endtask

    task automatic t_commit_byte();
        push(3); push(8'h31); push(8'h32);
        wr_valid  = 1'b1;
        wr_data   = 8'hEE;
        wr_commit = 1'b1;
        tick();
        wr_valid  = 1'b0;
        wr_commit = 1'b0;
        model_commit();
        chk("R10", "frame_count", int'(frame_count), 1);
        chk_window("R10");
        push(2); push(8'h44);
        wr_valid = 1'b1;
        wr_data  = 8'hEF;
        wr_abort = 1'b1;
        tick();
        wr_valid = 1'b0;
        wr_abort = 1'b0;
        pend.delete();
        send(2, 2, 8'h50);
        chk_status("R10");
        drain("R10");
    endtask

    task automatic t_release_empty();
        release_f();
        release_f();
        chk_status("R6");
        send(4, 4, 8'hC0);
        chk_window("R6");
        drain("R6");
    endtask

    task automatic t_overrun_wrap();
        for (int k = 0; k < 4; k++) send(13, 13, 16 * k);
        chk_status("R7");
        release_f();
        release_f();
        send(13, 13, 8'h80);
        send(13, 13, 8'h90);
        chk_status("R7");
        send(13, 13, 8'hE0);    // 65 bytes would be needed
        chk_status("R7");
        chk("R7", "overrun", int'(overrun), 1);
        chk_window("R7");
        tick();
        chk("R7", "overrun sticky", int'(overrun), 1);
        ovr_clr = 1'b1;
        tick();
        ovr_clr = 1'b0;
        m_ovr = 1'b0;
        chk("R7", "overrun cleared", int'(overrun), 0);
        send(12, 12, 8'hD0);    // exactly fills the store
        chk_status("R2");
        send(1, 1, 0);          // no room left
        chk_status("R7");
        ovr_clr = 1'b1;
        tick();
        ovr_clr = 1'b0;
        m_ovr = 1'b0;
        drain("R2");
    endtask

    task automatic t_win_high();
        send(13, 13, 8'h01);
        send(5, 5, 8'h11);
        for (int off = 13; off < 16; off++) begin
            win_offset = 4'(off);
            #1;
            chk("R8", "win_data high offset", int'(win_data), 0);
        end
        drain("R8");
    endtask

    task automatic t_concurrent();
        send(3, 3, 8'h60);
        push(5); push(8'h71); push(8'h72);
        chk("R9", "frame_count mid frame", int'(frame_count), 1);
        release_f();
        chk_status("R9");
        push(8'h73); push(8'h74);
        commit();
        chk_status("R9");
        chk_window("R9");
        push(2); push(8'h81);
        wr_commit     = 1'b1;
        frame_release = 1'b1;
        tick();
        wr_commit     = 1'b0;
        frame_release = 1'b0;
        model_release();
        model_commit();
        chk("R9", "frame_count commit+release", int'(frame_count), 1);
        chk_window("R9");
        drain("R9");
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        drain("R6");
        t_malformed();
        t_abort();
        t_commit_byte();
        t_release_empty();
        t_overrun_wrap();
        t_win_high();
        t_concurrent();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule